// File: doc/BRIEF.md
# Memory Boundary-Scan Test Port

This block is the serial test port of a synchronous memory die. A four-wire scan interface drives a sixteen-state controller. The wires are a test clock, a mode-select line, serial data in and serial data out, plus an optional asynchronous reset. A 3-bit instruction chooses which data register is placed between the serial input and the serial output. The choices are a one-flop pass-through stage, a 32-bit identity word, or a boundary chain whose length is a parameter (85 or 89 cells, depending on the package). Two of the boundary instructions also raise `hiz_force`, which tells the memory output drivers to float.

The boundary chain takes a parallel snapshot from `bsr_pins` during capture. It presents the shifted-in pattern on `bsr_out` after update. The identity word is built from fixed fields. One parameter selects the organisation field and another selects the package field. Codes the decoder does not know behave as the pass-through instruction and never touch the memory.

Controller states: ST_RESET, ST_IDLE, ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT1, ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPD, ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT1, ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPD.

Transitions (mode select 1 / 0):
- RESET→RESET/IDLE
- IDLE→DR_SEL/IDLE
- DR_SEL→IR_SEL/DR_CAP
- DR_CAP→DR_EXIT1/DR_SHIFT
- DR_SHIFT→DR_EXIT1/DR_SHIFT
- DR_EXIT1→DR_UPD/DR_PAUSE
- DR_PAUSE→DR_EXIT2/DR_PAUSE
- DR_EXIT2→DR_UPD/DR_SHIFT
- DR_UPD→DR_SEL/IDLE
- IR_SEL→RESET/IR_CAP

The IR_* states mirror the DR_* states. IR_UPD returns to DR_SEL/IDLE.

Top module: `mem_test_port`

## Requirements
- R1: Five consecutive rising test-clock edges with `tms` high put the controller in ST_RESET from any state. After that, the instruction is the identity code (001) and `hiz_force` is 0.
- R2: While `trst_n` is low, the controller is held in ST_RESET, the instruction is forced to 001, `hiz_force` is 0, `tdo_en` is 0 and `bsr_out` is all zeros. Releasing `trst_n` with `tms` low and then shifting the data path returns the identity word.
- R3: In ST_IR_CAP the 3-bit instruction shift stage loads 001. Shifting it out therefore yields 1, 0, 0 on `tdo`, least significant bit first.
- R4: Code 001 selects the 32-bit identity register, with the following fields:
  - bit 0 = 1
  - bits 11:1 = 00000110100
  - bits 17:12 = 100101 when WIDE_ORG=1, else 010101
  - bits 23:18 = 101001 when ALT_PACKAGE=0, else 000001
  - bits 28:24 = 01011
  - bits 31:29 = 000

  The word shifts out least significant bit first. A bit entering on `tdi` emerges 32 shifts later.
- R5: Code 111 and the spare codes 011, 101 and 110 select a 1-bit register that captures 0. These codes hold `hiz_force` at 0.
- R6: Codes 000 and 010 select the boundary chain, which captures `bsr_pins` (bit 0 emerges first). These codes drive `hiz_force` to 1.
- R7: Code 100 selects the boundary chain with the same capture behaviour and leaves `hiz_force` at 0.
- R8: On leaving ST_DR_UPD under code 000, 010 or 100, `bsr_out` takes the last BSR_LEN bits shifted in. Under any other code, `bsr_out` keeps its value.
- R9: `hiz_force` changes only on the falling edge in ST_IR_UPD or ST_RESET. It stays steady while a new instruction is being shifted.
- R10: `tdo` and `tdo_en` change on the falling test-clock edge. `tdo_en` is 1 only after a falling edge in ST_DR_SHIFT or ST_IR_SHIFT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| trst_n | input | 1 | Asynchronous test reset, active low |
| bsr_pins | input | BSR_LEN | Parallel snapshot of the I/O ring for capture |
| tdo | output | 1 | Serial data out, changes on falling edge |
| tdo_en | output | 1 | High while a shift state drives `tdo` |
| hiz_force | output | 1 | Forces memory output drivers to high impedance |
| bsr_out | output | BSR_LEN | Boundary values latched on update |

## Verification
The checker relies on `tms` and `tdi` being steady around each rising test-clock edge, and on `trst_n` changing only away from clock edges. The bench meets both conditions by changing every input one time unit after a falling edge.

The checker also assumes that `bsr_pins` is steady across the capture edge. The bench therefore loads each new pin pattern while the controller sits in ST_IDLE.

The five-ones reset check counts sampled mode-select values from reset release onward. The bench keeps the reset asserted until the clock is already running.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT1, ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPD,
        ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT1, ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPD
    } tap_st_e;

    typedef enum logic [IR_W-1:0] {
        OP_EXTEST  = 3'b000,
        OP_IDCODE  = 3'b001,
        OP_SAMPLEZ = 3'b010,
        OP_RSV3    = 3'b011,
        OP_SAMPLE  = 3'b100,
        OP_RSV5    = 3'b101,
        OP_RSV6    = 3'b110,
        OP_BYPASS  = 3'b111
    } op_e;

    // Strobes produced by the controller, one per action.
    typedef struct packed {
        logic cap_dr;
        logic sh_dr;
        logic upd_dr;
        logic cap_ir;
        logic sh_ir;
        logic upd_ir;
        logic tlr;
    } tap_ctl_t;

    // Identity word assembled from its fields.
    function automatic logic [ID_W-1:0] id_word(input bit wide_org, input bit alt_pkg);
        logic [2:0]  rev;
        logic [4:0]  depth;
        logic [5:0]  arch;
        logic [5:0]  dev;
        logic [10:0] vendor;
        rev    = 3'b000;
        depth  = 5'b01011;
        arch   = alt_pkg  ? 6'b000001 : 6'b101001;
        dev    = wide_org ? 6'b100101 : 6'b010101;
        vendor = 11'b00000110100;
        return {rev, depth, arch, dev, vendor, 1'b1};
    endfunction

endpackage

// File: rtl/mtp_fsm.sv
module mtp_fsm
    import mtp_pkg::*;
(
    input  logic     tck,
    input  logic     trst_n,
    input  logic     tms,
    output tap_st_e  state_o,
    output tap_ctl_t ctl_o
);

    tap_st_e state_q;
    tap_st_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:    state_d = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     state_d = tms ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   state_d = tms ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   state_d = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT: state_d = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1: state_d = tms ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: state_d = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2: state_d = tms ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   state_d = tms ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   state_d = tms ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   state_d = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT: state_d = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1: state_d = tms ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: state_d = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2: state_d = tms ? ST_IR_UPD   : ST_IR_SHIFT;
            ST_IR_UPD:   state_d = tms ? ST_DR_SEL   : ST_IDLE;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= ST_RESET;
        else         state_q <= state_d;
    end

    always_comb begin
        ctl_o        = '0;
        ctl_o.cap_dr = (state_q == ST_DR_CAP);
        ctl_o.sh_dr  = (state_q == ST_DR_SHIFT);
        ctl_o.upd_dr = (state_q == ST_DR_UPD);
        ctl_o.cap_ir = (state_q == ST_IR_CAP);
        ctl_o.sh_ir  = (state_q == ST_IR_SHIFT);
        ctl_o.upd_ir = (state_q == ST_IR_UPD);
        ctl_o.tlr    = (state_q == ST_RESET);
    end

    assign state_o = state_q;

endmodule

// File: rtl/mtp_ir.sv
module mtp_ir
    import mtp_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_ctl_t        ctl,
    output logic [IR_W-1:0] sr_o,
    output logic [IR_W-1:0] ir_o,
    output logic            so_o,
    output logic            sel_bsr_o,
    output logic            sel_id_o,
    output logic            hiz_o
);

    localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-2){1'b0}}, 2'b01};

    logic [IR_W-1:0] sr_q;
    op_e             ir_q;

    // Shift stage: rising edge, LSB out, TDI into MSB.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)        sr_q <= '0;
        else if (ctl.cap_ir) sr_q <= CAP_PAT;
        else if (ctl.sh_ir)  sr_q <= {tdi, sr_q[IR_W-1:1]};
    end

    // Active instruction: falling edge in update or test-logic-reset.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)         ir_q <= OP_IDCODE;
        else if (ctl.tlr)    ir_q <= OP_IDCODE;
        else if (ctl.upd_ir) ir_q <= op_e'(sr_q);
    end

    always_comb begin
        sel_bsr_o = 1'b0;
        sel_id_o  = 1'b0;
        hiz_o     = 1'b0;
        unique case (ir_q)
            OP_EXTEST:  begin sel_bsr_o = 1'b1; hiz_o = 1'b1; end
            OP_SAMPLEZ: begin sel_bsr_o = 1'b1; hiz_o = 1'b1; end
            OP_SAMPLE:  sel_bsr_o = 1'b1;
            OP_IDCODE:  sel_id_o  = 1'b1;
            OP_BYPASS, OP_RSV3, OP_RSV5, OP_RSV6: ;
        endcase
    end

    assign sr_o = sr_q;
    assign ir_o = ir_q;
    assign so_o = sr_q[0];

endmodule

// File: rtl/mtp_dr.sv
module mtp_dr
    import mtp_pkg::*;
#(
    parameter int              BSR_LEN = 85,
    parameter logic [ID_W-1:0] ID_VAL  = '0
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tdi,
    input  tap_ctl_t           ctl,
    input  logic               sel_bsr,
    input  logic               sel_id,
    input  logic [BSR_LEN-1:0] pins_i,
    output logic [BSR_LEN-1:0] upd_o,
    output logic               so_o
);

    logic               sel_byp;
    logic               byp_q;
    logic [ID_W-1:0]    id_q;
    logic [BSR_LEN-1:0] bsr_q;
    logic [BSR_LEN-1:0] upd_q;

    assign sel_byp = !sel_bsr && !sel_id;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                      byp_q <= 1'b0;
        else if (sel_byp && ctl.cap_dr)   byp_q <= 1'b0;
        else if (sel_byp && ctl.sh_dr)    byp_q <= tdi;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                      id_q <= '0;
        else if (sel_id && ctl.cap_dr)    id_q <= ID_VAL;
        else if (sel_id && ctl.sh_dr)     id_q <= {tdi, id_q[ID_W-1:1]};
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                      bsr_q <= '0;
        else if (sel_bsr && ctl.cap_dr)   bsr_q <= pins_i;
        else if (sel_bsr && ctl.sh_dr)    bsr_q <= {tdi, bsr_q[BSR_LEN-1:1]};
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)                      upd_q <= '0;
        else if (sel_bsr && ctl.upd_dr)   upd_q <= bsr_q;
    end

    always_comb begin
        if (sel_bsr)     so_o = bsr_q[0];
        else if (sel_id) so_o = id_q[0];
        else             so_o = byp_q;
    end

    assign upd_o = upd_q;

endmodule

// File: rtl/mem_test_port.sv
module mem_test_port
    import mtp_pkg::*;
#(
    parameter int BSR_LEN     = 85,
    parameter bit WIDE_ORG    = 1'b1,
    parameter bit ALT_PACKAGE = 1'b0
) (
    input  logic               tck,
    input  logic               tms,
    input  logic               tdi,
    input  logic               trst_n,
    input  logic [BSR_LEN-1:0] bsr_pins,
    output logic               tdo,
    output logic               tdo_en,
    output logic               hiz_force,
    output logic [BSR_LEN-1:0] bsr_out
);

    localparam logic [ID_W-1:0] ID_VAL = id_word(WIDE_ORG, ALT_PACKAGE);

    tap_st_e         state;
    tap_ctl_t        ctl;
    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] ir_q;
    logic            ir_so;
    logic            dr_so;
    logic            sel_bsr;
    logic            sel_id;
    logic            tdo_q;
    logic            en_q;

    mtp_fsm u_fsm (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_o (state),
        .ctl_o   (ctl)
    );

    mtp_ir u_ir (
        .tck       (tck),
        .trst_n    (trst_n),
        .tdi       (tdi),
        .ctl       (ctl),
        .sr_o      (ir_sr),
        .ir_o      (ir_q),
        .so_o      (ir_so),
        .sel_bsr_o (sel_bsr),
        .sel_id_o  (sel_id),
        .hiz_o     (hiz_force)
    );

    mtp_dr #(.BSR_LEN(BSR_LEN), .ID_VAL(ID_VAL)) u_dr (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .ctl     (ctl),
        .sel_bsr (sel_bsr),
        .sel_id  (sel_id),
        .pins_i  (bsr_pins),
        .upd_o   (bsr_out),
        .so_o    (dr_so)
    );

    // Serial output retimed to the falling edge.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            tdo_q <= ctl.sh_ir ? ir_so : (ctl.sh_dr ? dr_so : 1'b0);
            en_q  <= ctl.sh_ir || ctl.sh_dr;
        end
    end

    assign tdo    = tdo_q;
    assign tdo_en = en_q;

endmodule

// File: rtl/mtp_checker.sv
module mtp_checker
    import mtp_pkg::*;
(
    input logic            tck,
    input logic            trst_n,
    input logic            tms,
    input tap_st_e         st,
    input logic [IR_W-1:0] ir_q,
    input logic [IR_W-1:0] ir_sr,
    input logic            hiz,
    input logic            tdo_en
);

    logic [2:0] ones_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)        ones_q <= '0;
        else if (!tms)      ones_q <= '0;
        else if (ones_q < 3'd5) ones_q <= ones_q + 3'd1;
    end

    AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_q >= 3'd5) |-> (st == ST_RESET)); // R1

    AST_RESET_LOADS_ID: assert property (@(posedge tck) disable iff (!trst_n)
        (st == ST_RESET) |=> (ir_q == OP_IDCODE)); // R2

    AST_IR_CAPTURE_PAT: assert property (@(posedge tck) disable iff (!trst_n)
        (st == ST_IR_CAP) |=> (ir_sr == 3'b001)); // R3

    AST_HIZ_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
        !(st == ST_IR_UPD || st == ST_RESET) |-> $stable(hiz)); // R9

    AST_EN_IN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (st == ST_DR_SHIFT || st == ST_IR_SHIFT)); // R10

endmodule

bind mem_test_port mtp_checker u_chk (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .st     (state),
    .ir_q   (ir_q),
    .ir_sr  (ir_sr),
    .hiz    (hiz_force),
    .tdo_en (tdo_en)
);

// File: tb/test_mem_test_port.sv
module test_mem_test_port;

    localparam int P = 10;
    localparam int L = 85;

    logic         tck = 1'b0;
    logic         tms = 1'b1;
    logic         tdi = 1'b0;
    logic         trst_n = 1'b0;
    logic [L-1:0] bsr_pins = '0;
    logic         tdo;
    logic         tdo_en;
    logic         hiz_force;
    logic [L-1:0] bsr_out;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;
    logic s_tdo, s_en, s_hiz;

    mem_test_port #(.BSR_LEN(L), .WIDE_ORG(1'b1), .ALT_PACKAGE(1'b0)) i_mem_test_port (
        .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n), .bsr_pins(bsr_pins),
        .tdo(tdo), .tdo_en(tdo_en), .hiz_force(hiz_force), .bsr_out(bsr_out)
    );

    always #(P/2) tck = ~tck;

    localparam logic [31:0] EXP_ID = {3'b000, 5'b01011, 6'b101001, 6'b100101, 11'b00000110100, 1'b1};

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        #(P/4);
        s_tdo = tdo;
        s_en  = tdo_en;
        s_hiz = hiz_force;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    // From ST_IDLE; returns to ST_IDLE. hiz_ok stays 1 if hiz held during shifting.
    task automatic load_ir(input logic [2:0] code, output logic [2:0] cap, output bit hiz_ok, output bit en_ok);
        logic h0;
        h0 = hiz_force;
        hiz_ok = 1;
        en_ok = 1;
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 3; i++) begin
            step(i == 2, code[i]);
            cap[i] = s_tdo;
            if (s_hiz !== h0) hiz_ok = 0;
            if (s_en !== 1'b1) en_ok = 0;
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic shift_dr(input int n, input logic [127:0] din, output logic [127:0] dout);
        dout = '0;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i]);
            dout[i] = s_tdo;
        end
        step(1, 0); step(0, 0);
    endtask

    function automatic logic [L-1:0] pin_pat(input int code);
        logic [L-1:0] p;
        for (int i = 0; i < L; i++) p[i] = (((i * (code + 3)) + code) % 7) < 3;
        return p;
    endfunction

    function automatic logic [127:0] mask(input int n);
        return (128'd1 << n) - 128'd1;
    endfunction

    initial begin
        #(P * 150000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0]   cap;
        bit           hok, eok;
        logic [127:0] dout, din;
        logic [L-1:0] prev_out;

        repeat (3) @(negedge tck);
        // R2 reset state
        check("R2 hiz in reset", {127'd0, hiz_force}, 128'd0);
        check("R2 tdo_en in reset", {127'd0, tdo_en}, 128'd0);
        check("R2 bsr_out in reset", {43'd0, bsr_out}, 128'd0);
        #1 trst_n = 1'b1;
        step(0, 0);
        check("R10 en low in idle", {127'd0, s_en}, 128'd0);

        // R2/R4 default instruction and identity word
        din = {4{32'h5A3C_96E1}};
        shift_dr(64, din, dout);
        check("R4 id word after reset", dout[31:0], {96'd0, EXP_ID});
        check("R4 id passes tdi after 32", {96'd0, dout[63:32]}, {96'd0, din[31:0]});

        // Sweep all eight instruction codes
        prev_out = bsr_out;
        for (int c = 0; c < 8; c++) begin
            logic bsr_sel, id_sel, hexp;
            int   n;
            logic [127:0] exp;
            bsr_sel = (c == 0 || c == 2 || c == 4);
            id_sel  = (c == 1);
            hexp    = (c == 0 || c == 2);
            load_ir(c[2:0], cap, hok, eok);
            check("R3 ir capture 001", {125'd0, cap}, 128'd1);
            check("R9 hiz steady while shifting ir", {127'd0, hok}, 128'd1);
            check("R10 en high in shift-ir", {127'd0, eok}, 128'd1);
            check(bsr_sel ? (hexp ? "R6 hiz for code" : "R7 hiz for code") : "R5 hiz for code",
                  {127'd0, hiz_force}, {127'd0, hexp});
            bsr_pins = pin_pat(c);
            din = {4{32'hC3A5_0F71 ^ (32'h1111_1111 * c)}};
            n = bsr_sel ? L + 8 : (id_sel ? 40 : 9);
            shift_dr(n, din, dout);
            if (bsr_sel)     exp = (din << L) | {43'd0, pin_pat(c)};
            else if (id_sel) exp = (din << 32) | {96'd0, EXP_ID};
            else             exp = din << 1;
            check(bsr_sel ? (hexp ? "R6 boundary capture/shift" : "R7 boundary capture/shift")
                          : (id_sel ? "R4 id shift" : "R5 bypass shift"),
                  dout & mask(n), exp & mask(n));
            if (bsr_sel) prev_out = din[L+7:8];
            check("R8 bsr_out after update", {43'd0, bsr_out}, {43'd0, prev_out});
            check("R10 en low after shift", {127'd0, tdo_en}, 128'd0);
        end

        // R1: five ones from within Shift-DR after EXTEST
        load_ir(3'b000, cap, hok, eok);
        check("R6 extest hiz", {127'd0, hiz_force}, 128'd1);
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 5; i++) step(1, 0);
        check("R1 hiz cleared by tms reset", {127'd0, hiz_force}, 128'd0);
        step(0, 0);
        shift_dr(32, '0, dout);
        check("R1 idcode after tms reset", dout[31:0], {96'd0, EXP_ID});

        // R1: from Pause-IR
        load_ir(3'b010, cap, hok, eok);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0); step(1, 0); step(0, 0);
        check("R9 hiz held in pause-ir", {127'd0, hiz_force}, 128'd1);
        for (int i = 0; i < 5; i++) step(1, 0);
        step(0, 0);
        shift_dr(32, '0, dout);
        check("R1 idcode from pause-ir", dout[31:0], {96'd0, EXP_ID});

        // R2: asynchronous reset mid-run
        load_ir(3'b000, cap, hok, eok);
        trst_n = 1'b0;
        #1;
        check("R2 async hiz clear", {127'd0, hiz_force}, 128'd0);
        check("R2 async bsr_out clear", {43'd0, bsr_out}, 128'd0);
        @(negedge tck);
        #1 trst_n = 1'b1;
        step(0, 0);
        shift_dr(32, '0, dout);
        check("R2 idcode after trst", dout[31:0], {96'd0, EXP_ID});

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule